// File: doc/BRIEF.md
# Store Buffer Ordering Unit with Watchlist Fences

This unit sits between the in-order request stream of one processor core and a single-ported memory. It accepts load, store and fence requests over a valid/ready handshake and enforces total store ordering. Stores go into a FIFO buffer and drain to memory in the order they arrived. A younger load may reach memory ahead of older buffered stores to other addresses. A load that hits buffered data is answered from the buffer.

Each fence runs in one of two modes, chosen by `fence_mode` when the fence is accepted. In conservative mode the fence holds back every later access until the stores that were buffered at the fence have reached memory. In watchlist mode the block compares each later access against a small programmable address list. An access whose address is not on the list passes the fence at once. An access whose address is on the list waits until those older stores have drained. When the fence retires, the list is cleared. Software or a neighbouring agent fills the list through a simple indexed write port.

Top module: `mou_ordering_unit`

## Requirements
- R1: A load whose address matches no buffered store is accepted in any cycle where `mem_ready` is high and no fence holds it back, even while older stores are buffered. In that same cycle it appears on the memory port as a read (`mem_valid`=1, `mem_we`=0, `mem_addr` = load address).
- R2: Buffered stores leave through the memory port as writes, at most one per cycle, in acceptance order and with their own address and data. The memory port is used only while `mem_ready` is high, and a load miss takes priority over a drain.
- R3: A load whose address matches one or more buffered stores gets the data of the youngest matching store and issues no memory read.
- R4: After a fence with `fence_mode`=0 is accepted while stores are buffered, `req_ready` stays low for loads, stores and fences until the last of those stores has drained. It goes high again in the cycle after that drain.
- R5: While a fence with `fence_mode`=1 is outstanding, a load or store whose address is on no valid watchlist entry is accepted as if there were no fence.
- R6: While a fence with `fence_mode`=1 is outstanding, a load or store whose address is on a valid watchlist entry is held (`req_ready`=0) until the stores buffered before the fence have drained.
- R7: A fence with `fence_mode`=1 whose watchlist is empty never lowers `req_ready` for loads or stores.
- R8: A write with `wl_we`=1 sets watchlist entry `wl_idx` to `wl_addr` and marks it valid. Every entry becomes invalid when a fence retires. A write in the same cycle as a retire wins for its entry.
- R9: Only one fence is outstanding at a time: a fence request sees `req_ready`=0 while a fence is pending. A fence accepted with an empty buffer retires at once.
- R10: When the buffer holds `SB_DEPTH` stores, a store request sees `req_ready`=0.
- R11: Op codes are 00 = load, 01 = store, 10 = fence, 11 = no operation. Every accepted load produces exactly one `rsp_valid` pulse in the following cycle, so responses come back in program order. No pulse appears otherwise.
- R12: After reset the buffer is empty, no fence is pending, the watchlist is empty, `rsp_valid` and `mem_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 00 load, 01 store, 10 fence, 11 no operation |
| req_addr | input | AW | Word address of a load or store |
| req_wdata | input | DW | Store data |
| fence_mode | input | 1 | Sampled with a fence: 0 conservative, 1 watchlist |
| wl_we | input | 1 | Watchlist entry write strobe |
| wl_idx | input | $clog2(WL_ENTRIES) | Watchlist entry selected for the write |
| wl_addr | input | AW | Address written into the watchlist entry |
| mem_ready | input | 1 | Memory port free this cycle |
| mem_valid | output | 1 | Memory access this cycle (only while mem_ready) |
| mem_we | output | 1 | 1 write (store drain), 0 read (load) |
| mem_addr | output | AW | Memory access address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| rsp_valid | output | 1 | Load response pulse |
| rsp_data | output | DW | Load response data |

## Verification
A load miss shows on the memory port in the same cycle it is accepted. A buffer drain shows on the port in the cycle it happens. The bench drives at the falling edge and samples these combinational outputs one nanosecond later, before the next rising edge. Every load response is due exactly one cycle after acceptance, so the bench checks `rsp_valid` and `rsp_data` at the next falling edge. A fence release is due in the cycle after the last older store drains. The directed fence tests hold a request and count the stalled cycles against the number of stores buffered ahead of the fence.

// File: rtl/mou_pkg.sv
`timescale 1ns/1ps
package mou_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_FENCE = 2'b10,
      OP_NOP   = 2'b11
   } mou_op_e;
endpackage

// File: rtl/mou_store_fifo.sv
`timescale 1ns/1ps
// Circular store buffer with a youngest-match lookup for load forwarding.
module mou_store_fifo #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   input  logic [AW-1:0] lk_addr,
   output logic          lk_hit,
   output logic [DW-1:0] lk_data
);
   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= tail_q + PW'(1);
         if (pop)  head_q <= head_q + PW'(1);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[tail_q] <= push_addr;
         data_q[tail_q] <= push_data;
      end
   end

   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign count     = cnt_q;
   assign head_addr = addr_q[head_q];
   assign head_data = data_q[head_q];

   // Scan from oldest to youngest; a later match overrides, leaving the youngest.
   always_comb begin
      lk_hit  = 1'b0;
      lk_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if ((CW'(i) < cnt_q) && (addr_q[head_q + PW'(i)] == lk_addr)) begin
            lk_hit  = 1'b1;
            lk_data = data_q[head_q + PW'(i)];
         end
      end
   end
endmodule

// File: rtl/mou_watchlist.sv
`timescale 1ns/1ps
// Small address list that a pending address-aware fence compares accesses against.
module mou_watchlist #(
   parameter int AW      = 16,
   parameter int ENTRIES = 4,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_addr,
   input  logic          clear,
   input  logic [AW-1:0] chk_addr,
   output logic          hit
);
   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic          vld_q;
      logic [AW-1:0] addr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
         end else if (wr_en && (wr_idx == IW'(g))) begin
            vld_q  <= 1'b1;
            addr_q <= wr_addr;
         end else if (clear) begin
            vld_q  <= 1'b0;
         end
      end

      assign match[g] = vld_q && (addr_q == chk_addr);
   end

   assign hit = |match;
endmodule

// File: rtl/mou_fence_ctrl.sv
`timescale 1ns/1ps
// Tracks the single outstanding fence: how many older stores remain and its mode.
module mou_fence_ctrl #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fence_fire,
   input  logic          mode_in,
   input  logic [CW-1:0] occ_after,
   input  logic          drain,
   output logic          busy,
   output logic          aware,
   output logic          retire
);
   logic [CW-1:0] pend_q;
   logic          busy_q, aware_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         busy_q  <= 1'b0;
         aware_q <= 1'b0;
      end else if (fence_fire) begin
         pend_q  <= occ_after;
         busy_q  <= (occ_after != '0);
         aware_q <= mode_in;
      end else if (busy_q && drain) begin
         pend_q <= pend_q - CW'(1);
         if (pend_q == CW'(1)) busy_q <= 1'b0;
      end
   end

   assign busy   = busy_q;
   assign aware  = aware_q;
   assign retire = (fence_fire && (occ_after == '0)) ||
                   (busy_q && drain && (pend_q == CW'(1)));
endmodule

// File: rtl/mou_ordering_unit.sv
`timescale 1ns/1ps
// Total-store-order unit with FIFO store buffer and conservative/watchlist fences.
module mou_ordering_unit
   import mou_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 32,
   parameter int SB_DEPTH   = 8,
   parameter int WL_ENTRIES = 4,
   localparam int IW        = $clog2(WL_ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          fence_mode,
   input  logic          wl_we,
   input  logic [IW-1:0] wl_idx,
   input  logic [AW-1:0] wl_addr,
   input  logic          mem_ready,
   output logic          mem_valid,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);
   localparam int CW = $clog2(SB_DEPTH) + 1;

   if (SB_DEPTH < 2 || (SB_DEPTH & (SB_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("SB_DEPTH must be a power of two of at least 2");
   end
   if (WL_ENTRIES < 2 || (WL_ENTRIES & (WL_ENTRIES - 1)) != 0) begin : g_bad_wl
      $error("WL_ENTRIES must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("AW and DW must be positive");
   end

   mou_op_e op;
   assign op = mou_op_e'(req_op);

   logic          sb_full, sb_empty, fwd_hit, wl_hit;
   logic [CW-1:0] sb_count;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data, fwd_data;
   logic          fence_busy, fence_aware, fence_retire;
   logic          fence_block, load_fire, store_fire, fence_fire, load_miss, drain;
   logic [CW-1:0] occ_after;

   // A pending fence holds an access if it is conservative, or if the address is watched.
   assign fence_block = fence_busy && (!fence_aware || wl_hit);

   always_comb begin
      unique case (op)
         OP_LOAD:  req_ready = !fence_block && (fwd_hit || mem_ready);
         OP_STORE: req_ready = !fence_block && !sb_full;
         OP_FENCE: req_ready = !fence_busy;
         default:  req_ready = 1'b1;
      endcase
   end

   assign load_fire  = req_valid && req_ready && (op == OP_LOAD);
   assign store_fire = req_valid && req_ready && (op == OP_STORE);
   assign fence_fire = req_valid && req_ready && (op == OP_FENCE);
   assign load_miss  = load_fire && !fwd_hit;
   assign drain      = !sb_empty && mem_ready && !load_miss;
   assign occ_after  = sb_count - CW'(drain);

   mou_store_fifo #(
      .AW(AW), .DW(DW), .DEPTH(SB_DEPTH)
   ) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (store_fire),
      .push_addr (req_addr),
      .push_data (req_wdata),
      .pop       (drain),
      .full      (sb_full),
      .empty     (sb_empty),
      .count     (sb_count),
      .head_addr (head_addr),
      .head_data (head_data),
      .lk_addr   (req_addr),
      .lk_hit    (fwd_hit),
      .lk_data   (fwd_data)
   );

   mou_watchlist #(
      .AW(AW), .ENTRIES(WL_ENTRIES)
   ) u_wl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wl_we),
      .wr_idx   (wl_idx),
      .wr_addr  (wl_addr),
      .clear    (fence_retire),
      .chk_addr (req_addr),
      .hit      (wl_hit)
   );

   mou_fence_ctrl #(
      .CW(CW)
   ) u_fence (
      .clk        (clk),
      .rst_n      (rst_n),
      .fence_fire (fence_fire),
      .mode_in    (fence_mode),
      .occ_after  (occ_after),
      .drain      (drain),
      .busy       (fence_busy),
      .aware      (fence_aware),
      .retire     (fence_retire)
   );

   // Memory port: a load miss wins the port; otherwise the oldest store drains.
   assign mem_valid = load_miss || drain;
   assign mem_we    = drain;
   assign mem_addr  = load_miss ? req_addr : head_addr;
   assign mem_wdata = head_data;

   logic          rsp_q, fwd_sel_q;
   logic [DW-1:0] fwd_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q      <= 1'b0;
         fwd_sel_q  <= 1'b0;
         fwd_data_q <= '0;
      end else begin
         rsp_q     <= load_fire;
         fwd_sel_q <= load_fire && fwd_hit;
         if (load_fire && fwd_hit) fwd_data_q <= fwd_data;
      end
   end

   assign rsp_valid = rsp_q;
   assign rsp_data  = fwd_sel_q ? fwd_data_q : mem_rdata;
endmodule

// File: rtl/mou_ordering_unit_chk.sv
`timescale 1ns/1ps
module mou_ordering_unit_chk
   import mou_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [1:0]    req_op,
   input logic [AW-1:0] req_addr,
   input logic          mem_ready,
   input logic          mem_valid,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          rsp_valid,
   input logic          fwd_hit,
   input logic          fence_busy,
   input logic          fence_aware,
   input logic          sb_full,
   input logic [CW-1:0] sb_count
);
   logic ld_fire;
   assign ld_fire = req_valid && req_ready && (req_op == OP_LOAD);

   p_load_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && !fwd_hit) |-> (mem_valid && !mem_we && mem_addr == req_addr));

   p_port_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_ready);

   p_fwd_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && fwd_hit) |-> !(mem_valid && !mem_we));

   p_cons_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_busy && !fence_aware && req_valid && req_op != OP_NOP) |-> !req_ready);

   p_fence_has_work_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fence_busy |-> (sb_count != '0));

   p_one_fence_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_busy && req_op == OP_FENCE) |-> !req_ready);

   p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_full && req_op == OP_STORE) |-> !req_ready);

   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fire |=> rsp_valid);

   p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_fire |=> !rsp_valid);
endmodule

bind mou_ordering_unit mou_ordering_unit_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_op      (req_op),
   .req_addr    (req_addr),
   .mem_ready   (mem_ready),
   .mem_valid   (mem_valid),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .rsp_valid   (rsp_valid),
   .fwd_hit     (fwd_hit),
   .fence_busy  (fence_busy),
   .fence_aware (fence_aware),
   .sb_full     (sb_full),
   .sb_count    (sb_count)
);

// File: tb/mou_ordering_unit_tb.sv
`timescale 1ns/1ps
module mou_ordering_unit_tb;
   localparam int AW = 16, DW = 32, DEPTH = 8, WLN = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, req_valid, req_ready, fence_mode, wl_we, mem_ready;
   logic [1:0]    req_op, wl_idx;
   logic [AW-1:0] req_addr, wl_addr, mem_addr;
   logic [DW-1:0] req_wdata, mem_wdata, mem_rdata, rsp_data;
   logic          mem_valid, mem_we, rsp_valid;

   mou_ordering_unit #(.AW(AW), .DW(DW), .SB_DEPTH(DEPTH), .WL_ENTRIES(WLN)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .fence_mode(fence_mode), .wl_we(wl_we), .wl_idx(wl_idx), .wl_addr(wl_addr),
      .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   // Bench memory: read data returns one cycle after the read.
   logic [DW-1:0] mem [256];
   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   // Reference model: memory image plus program-order queue of undrained stores.
   logic [DW-1:0] model_mem [256];
   logic [AW-1:0] ms_addr [32];
   logic [DW-1:0] ms_data [32];
   int            ms_n;
   int            n_vec, n_bad;
   bit            fired, done;

   function automatic logic [DW-1:0] init_val(input int i);
      return 32'hA000_0000 + 32'(i) * 32'd7;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d);
      h = 1'b0;
      d = model_mem[a[7:0]];
      for (int i = 0; i < ms_n; i++) begin
         if (ms_addr[i] == a) begin
            h = 1'b1;
            d = ms_data[i];
         end
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic do_cycle(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
      logic          h;
      logic [DW-1:0] ed;
      bit            was_load;
      req_valid = v; req_op = op; req_addr = a; req_wdata = d;
      #1;
      fired = v && req_ready;
      was_load = fired && (op == 2'b00);
      lookup(a, h, ed);
      if (was_load) begin
         if (h) chk(!(mem_valid && !mem_we), "R3 no read on forward", 64'(mem_valid), 0);
         else   chk(mem_valid && !mem_we && mem_addr == a, "R1 load read issued",
                    {mem_valid, mem_we, 14'd0, mem_addr}, {2'b10, 14'd0, a});
      end
      if (mem_valid && mem_we) begin
         chk(ms_n > 0 && mem_addr == ms_addr[0] && mem_wdata == ms_data[0], "R2 drain order",
             {16'd0, mem_addr, mem_wdata}, {16'd0, ms_addr[0], ms_data[0]});
         if (ms_n > 0) begin
            model_mem[ms_addr[0][7:0]] = ms_data[0];
            for (int i = 1; i < ms_n; i++) begin
               ms_addr[i-1] = ms_addr[i];
               ms_data[i-1] = ms_data[i];
            end
            ms_n--;
         end
      end
      if (fired && op == 2'b01) begin
         ms_addr[ms_n] = a;
         ms_data[ms_n] = d;
         ms_n++;
      end
      @(posedge clk);
      @(negedge clk);
      wl_we = 1'b0;
      if (was_load) chk(rsp_valid && rsp_data == ed, h ? "R3 forwarded data" : "R11 load response",
                        {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, ed});
      else          chk(!rsp_valid, "R11 no stray response", 64'(rsp_valid), 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) do_cycle(1'b0, 2'b11, '0, '0);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      int stalls;
      n_vec = 0; n_bad = 0; ms_n = 0; done = 0;
      for (int i = 0; i < 256; i++) begin
         mem[i] = init_val(i);
         model_mem[i] = init_val(i);
      end
      rst_n = 1'b0; req_valid = 0; req_op = 2'b11; req_addr = '0; req_wdata = '0;
      fence_mode = 0; wl_we = 0; wl_idx = '0; wl_addr = '0; mem_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      req_valid = 1'b1; req_op = 2'b01; #1;
      chk(req_ready && !rsp_valid && !mem_valid, "R12 reset state",
          {req_ready, rsp_valid, mem_valid}, 3'b100);
      req_valid = 1'b0; @(negedge clk);

      // R10, R3: fill buffer with memory busy; addresses 0..3 each stored twice
      mem_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) do_cycle(1'b1, 2'b01, AW'(i % 4), 32'd100 + 32'(i));
      do_cycle(1'b1, 2'b01, 16'd9, 32'd1);
      chk(!fired, "R10 full buffer stalls store", 64'(fired), 0);
      do_cycle(1'b1, 2'b00, 16'd9, '0);
      chk(!fired, "R1 load miss waits for port", 64'(fired), 0);
      do_cycle(1'b1, 2'b00, 16'd2, '0);
      chk(fired, "R3 youngest forward accepted", 64'(fired), 1);

      // R1: load miss bypasses the buffered stores
      mem_ready = 1'b1;
      do_cycle(1'b1, 2'b00, 16'd12, '0);
      chk(fired, "R1 load passes buffered stores", 64'(fired), 1);
      idle(DEPTH + 2);
      chk(ms_n == 0, "R2 all stores drained", 64'(ms_n), 0);

      // R4: conservative fence with two stores ahead
      mem_ready = 1'b0;
      do_cycle(1'b1, 2'b01, 16'd20, 32'd220);
      do_cycle(1'b1, 2'b01, 16'd21, 32'd221);
      fence_mode = 1'b0;
      do_cycle(1'b1, 2'b10, '0, '0);
      chk(fired, "R4 fence accepted", 64'(fired), 1);
      do_cycle(1'b1, 2'b01, 16'd30, 32'd5);
      chk(!fired, "R4 store held by conservative fence", 64'(fired), 0);
      do_cycle(1'b1, 2'b00, 16'd20, '0);
      chk(!fired, "R4 forwardable load held", 64'(fired), 0);
      mem_ready = 1'b1;
      stalls = 0;
      for (int k = 0; k < 20; k++) begin
         do_cycle(1'b1, 2'b00, 16'd30, '0);
         if (fired) break;
         stalls++;
      end
      chk(stalls == 2, "R4 release after last older store", 64'(stalls), 2);

      // R5, R6, R9: watchlist fence
      wl_we = 1'b1; wl_idx = 2'd0; wl_addr = 16'd40; do_cycle(1'b0, 2'b11, '0, '0);
      wl_we = 1'b1; wl_idx = 2'd1; wl_addr = 16'd41; do_cycle(1'b0, 2'b11, '0, '0);
      mem_ready = 1'b0;
      do_cycle(1'b1, 2'b01, 16'd50, 32'd350);
      do_cycle(1'b1, 2'b01, 16'd51, 32'd351);
      fence_mode = 1'b1;
      do_cycle(1'b1, 2'b10, '0, '0);
      fence_mode = 1'b0;
      do_cycle(1'b1, 2'b01, 16'd60, 32'd360);
      chk(fired, "R5 unwatched store passes fence", 64'(fired), 1);
      do_cycle(1'b1, 2'b00, 16'd50, '0);
      chk(fired, "R5 unwatched load passes fence", 64'(fired), 1);
      do_cycle(1'b1, 2'b00, 16'd40, '0);
      chk(!fired, "R6 watched load held", 64'(fired), 0);
      do_cycle(1'b1, 2'b01, 16'd41, 32'd9);
      chk(!fired, "R6 watched store held", 64'(fired), 0);
      do_cycle(1'b1, 2'b10, '0, '0);
      chk(!fired, "R9 second fence held", 64'(fired), 0);
      mem_ready = 1'b1;
      stalls = 0;
      for (int k = 0; k < 20; k++) begin
         do_cycle(1'b1, 2'b00, 16'd40, '0);
         if (fired) break;
         stalls++;
      end
      chk(stalls == 2, "R6 watched load released after older stores", 64'(stalls), 2);
      idle(4);

      // R8, R7: watchlist cleared on retire; empty list costs nothing
      mem_ready = 1'b0;
      do_cycle(1'b1, 2'b01, 16'd80, 32'd480);
      do_cycle(1'b1, 2'b01, 16'd81, 32'd481);
      fence_mode = 1'b1;
      do_cycle(1'b1, 2'b10, '0, '0);
      chk(fired, "R7 watchlist fence accepted", 64'(fired), 1);
      do_cycle(1'b1, 2'b01, 16'd41, 32'd441);
      chk(fired, "R8 entry cleared by retire", 64'(fired), 1);
      do_cycle(1'b1, 2'b00, 16'd80, '0);
      chk(fired, "R7 load not stalled by empty list", 64'(fired), 1);
      do_cycle(1'b1, 2'b01, 16'd82, 32'd482);
      chk(fired, "R7 store not stalled by empty list", 64'(fired), 1);
      mem_ready = 1'b1;
      idle(6);

      // R9: fences with empty buffer retire at once
      do_cycle(1'b1, 2'b10, '0, '0);
      chk(fired, "R9 first fence on empty buffer", 64'(fired), 1);
      do_cycle(1'b1, 2'b10, '0, '0);
      chk(fired, "R9 back-to-back fence", 64'(fired), 1);

      // Random mix with fixed seed
      void'($urandom(32'd4242));
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [1:0] op;
         r = int'($urandom_range(0, 99));
         op = (r < 40) ? 2'b00 : (r < 85) ? 2'b01 : (r < 93) ? 2'b10 : 2'b11;
         mem_ready  = ($urandom_range(0, 9) < 7);
         fence_mode = $urandom_range(0, 1) == 1;
         if ($urandom_range(0, 9) == 0) begin
            wl_we = 1'b1;
            wl_idx = 2'($urandom_range(0, 3));
            wl_addr = AW'($urandom_range(0, 15));
         end
         do_cycle(1'b1, op, AW'($urandom_range(0, 15)), $urandom);
      end
      mem_ready = 1'b1;
      idle(DEPTH + 4);
      chk(ms_n == 0, "R2 random run fully drained", 64'(ms_n), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule